// File: doc/BRIEF.md
# Two-channel DAC data holding and trigger front end

This block is the digital side of a two-channel 12-bit digital-to-analog converter. A byte-wide write bus loads each channel's 12-bit holding value through one of three alignment views, or loads both channels at once through shared dual views. A per-channel transfer then copies the holding value into the output word that feeds the converter. The transfer happens either right after a committing write (untriggered operation) or when a selected trigger arrives. The trigger can be timer pulse A, timer pulse B, a rising edge on an asynchronous external pin, or a self-clearing software bit.

Each channel has a six-bit configuration byte. Bit 0 enables the channel, bit 1 enables triggering, bits 3:2 select the source (0 timer A, 1 timer B, 2 external pin, 3 software), bit 4 turns the output buffer off and bit 5 enables DMA requests. While a channel is enabled its source field cannot be changed. A hardware trigger on a channel with DMA enabled raises a one-cycle request. The asynchronous reset is active low, and its release is assumed to be synchronised upstream.

Top module: `dac_hold_trig`

## Requirements
- R1: After reset both output words, both DMA requests, the enable outputs and the buffer-off outputs are zero.
- R2: Channel c (c = 0 or 1, base address 4 + 5c) takes a high nibble at base+0 (bits 3:0 of the byte), and a write at base+1 commits {nibble, byte} to the holding value. A high-nibble write on its own leaves the output unchanged.
- R3: The left-aligned view takes value bits 11:4 at base+2, and a write at base+3 commits with bits 3:0 taken from the upper nibble of that byte.
- R4: A write at base+4 commits the byte as value bits 11:4, with bits 3:0 cleared.
- R5: With the channel enabled and triggering off, the output word takes the committed value at the second rising edge, counting the edge that samples the committing write as the first.
- R6: A disabled channel never updates its output word.
- R7: With triggering on and a timer source, a timer pulse sampled at an edge updates the output at the following edge. Writes alone, and pulses on the other timer, do not update it.
- R8: With the external source, the pin passes through two synchronising flops. The output updates at the fourth edge, counting the first edge that samples the pin high. A pin held high or falling gives no further transfer.
- R9: Writing 1 to bit c of address 2 arms the software trigger of channel c. The output updates at the third edge, counting the write edge as the first. The bit clears when the trigger is taken, so later writes are not transferred.
- R10: The configuration byte is written at address c. While the channel's enable bit is already set, the source field keeps its old value and the other fields are still written.
- R11: With DMA enabled and a timer or external source, each taken trigger gives a dma_req pulse one cycle long, in the cycle before the output changes. The software source never raises dma_req.
- R12: Dual views: address 14 buffers the channel 0 byte and address 15 commits both channels in 8-bit form. Addresses 16 and 18 take the high nibbles, address 17 buffers the channel 0 low byte, and address 19 commits both channels in 12-bit right-aligned form.
- R13: ch_en and buf_off show bits 0 and 4 of each channel's configuration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Write data byte |
| tmr_a | input | 1 | Timer A trigger pulse |
| tmr_b | input | 1 | Timer B trigger pulse |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| dout0 | output | 12 | Channel 0 output word |
| dout1 | output | 12 | Channel 1 output word |
| dma_req | output | 2 | Per-channel DMA request pulse |
| ch_en | output | 2 | Per-channel enable |
| buf_off | output | 2 | Per-channel output-buffer-off |

## Verification
The bench aims at the write that sets enable and changes the source in the same byte, and at the write that clears enable in the same byte. A design that checked the new enable bit instead of the old one would let the source change and would fire on the wrong timer. It also tests a software trigger armed with DMA enabled, where a wrong design would raise a request or transfer again once it had cleared. It tests a high nibble written without its low byte and a dual commit, where a design that committed too early would show a half-written value. Finally it counts the exact edge of each transfer through the synchroniser, where an extra or missing flop would move the update by a cycle.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int NCH    = 2;
  localparam int DATA_W = 12;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    SRC_TMR_A = 2'd0,
    SRC_TMR_B = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_SW    = 2'd3
  } trig_src_e;

  typedef struct packed {
    logic      dma_en;
    logic      buf_off;
    trig_src_e src;
    logic      trig_en;
    logic      en;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  localparam int A_CFG0    = 0;
  localparam int A_SWTRIG  = 2;
  localparam int A_CH_BASE = 4;
  localparam int A_CH_STEP = 5;
  localparam int V_RHI     = 0;
  localparam int V_RLO     = 1;
  localparam int V_LHI     = 2;
  localparam int V_LLO     = 3;
  localparam int V_R8      = 4;
  localparam int A_D8_0    = 14;
  localparam int A_D8_1    = 15;
  localparam int A_DR_HI0  = 16;
  localparam int A_DR_LO0  = 17;
  localparam int A_DR_HI1  = 18;
  localparam int A_DR_LO1  = 19;
endpackage

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs
  import dac_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BUS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [BW-1:0]         wr_data,
  input  logic [NCH-1:0]        sw_take,
  output chan_cfg_t [NCH-1:0]   cfg,
  output logic [NCH-1:0]        sw_pend
);
  chan_cfg_t [NCH-1:0] cfg_q, cfg_n;
  logic [NCH-1:0]      sw_q, sw_n;

  always_comb begin
    cfg_n = cfg_q;
    sw_n  = sw_q & ~sw_take;
    for (int c = 0; c < NCH; c++) begin
      if (wr_en && wr_addr == AW'(A_CFG0 + c)) begin
        cfg_n[c] = chan_cfg_t'(wr_data[CFG_W-1:0]);
        if (cfg_q[c].en) cfg_n[c].src = cfg_q[c].src;
      end
    end
    if (wr_en && wr_addr == AW'(A_SWTRIG)) sw_n = sw_n | wr_data[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sw_q  <= '0;
    end else begin
      cfg_q <= cfg_n;
      sw_q  <= sw_n;
    end
  end

  assign cfg     = cfg_q;
  assign sw_pend = sw_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[g].en |=> cfg_q[g].src == $past(cfg_q[g].src)); // R10
  end
endmodule

// File: rtl/dac_hold.sv
module dac_hold
  import dac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BUS_W,
  parameter int AW = ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [BW-1:0]           wr_data,
  output logic [NCH-1:0][DW-1:0]  hold,
  output logic [NCH-1:0]          commit
);
  localparam int LW = DW - BW;

  logic [NCH-1:0][DW-1:0] hold_q, hold_n;
  logic [NCH-1:0][LW-1:0] rhi_q, rhi_n;
  logic [NCH-1:0][BW-1:0] lhi_q, lhi_n;
  logic [BW-1:0]          d8_q, d8_n, dlo_q, dlo_n;

  always_comb begin
    hold_n = hold_q;
    rhi_n  = rhi_q;
    lhi_n  = lhi_q;
    d8_n   = d8_q;
    dlo_n  = dlo_q;
    commit = '0;
    if (wr_en) begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr == AW'(A_CH_BASE + c*A_CH_STEP + V_RHI)) rhi_n[c] = wr_data[LW-1:0];
        if (wr_addr == AW'(A_CH_BASE + c*A_CH_STEP + V_RLO)) begin
          hold_n[c] = {rhi_q[c], wr_data};
          commit[c] = 1'b1;
        end
        if (wr_addr == AW'(A_CH_BASE + c*A_CH_STEP + V_LHI)) lhi_n[c] = wr_data;
        if (wr_addr == AW'(A_CH_BASE + c*A_CH_STEP + V_LLO)) begin
          hold_n[c] = {lhi_q[c], wr_data[BW-1 -: LW]};
          commit[c] = 1'b1;
        end
        if (wr_addr == AW'(A_CH_BASE + c*A_CH_STEP + V_R8)) begin
          hold_n[c] = {wr_data, {LW{1'b0}}};
          commit[c] = 1'b1;
        end
      end
      if (wr_addr == AW'(A_D8_0)) d8_n = wr_data;
      if (wr_addr == AW'(A_D8_1)) begin
        hold_n[0] = {d8_q, {LW{1'b0}}};
        hold_n[1] = {wr_data, {LW{1'b0}}};
        commit    = '1;
      end
      if (wr_addr == AW'(A_DR_HI0)) rhi_n[0] = wr_data[LW-1:0];
      if (wr_addr == AW'(A_DR_HI1)) rhi_n[1] = wr_data[LW-1:0];
      if (wr_addr == AW'(A_DR_LO0)) dlo_n = wr_data;
      if (wr_addr == AW'(A_DR_LO1)) begin
        hold_n[0] = {rhi_q[0], dlo_q};
        hold_n[1] = {rhi_q[1], wr_data};
        commit    = '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      rhi_q  <= '0;
      lhi_q  <= '0;
      d8_q   <= '0;
      dlo_q  <= '0;
    end else begin
      hold_q <= hold_n;
      rhi_q  <= rhi_n;
      lhi_q  <= lhi_n;
      d8_q   <= d8_n;
      dlo_q  <= dlo_n;
    end
  end

  assign hold = hold_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_HOLD_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !commit[g] |=> $stable(hold_q[g])); // R2
  end
endmodule

// File: rtl/dac_ext_sync.sv
module dac_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_n;

  always_comb sh_n = {sh_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: rtl/dac_chan_xfer.sv
module dac_chan_xfer
  import dac_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chan_cfg_t     cfg,
  input  logic          tmr_a,
  input  logic          tmr_b,
  input  logic          ext_rise,
  input  logic          sw_pend,
  input  logic          commit,
  input  logic [DW-1:0] hold,
  output logic [DW-1:0] dout,
  output logic          dreq,
  output logic          take_sw
);
  logic          src_hit, hit;
  logic          xfer_q, xfer_n, dreq_q, dreq_n;
  logic [DW-1:0] out_q, out_n;

  always_comb begin
    unique case (cfg.src)
      SRC_TMR_A: src_hit = tmr_a;
      SRC_TMR_B: src_hit = tmr_b;
      SRC_EXT:   src_hit = ext_rise;
      default:   src_hit = sw_pend;
    endcase
    hit     = cfg.en & cfg.trig_en & src_hit;
    take_sw = hit & (cfg.src == SRC_SW);
    xfer_n  = cfg.en & (cfg.trig_en ? hit : commit);
    dreq_n  = hit & cfg.dma_en & (cfg.src != SRC_SW);
    out_n   = xfer_q ? hold : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= 1'b0;
      dreq_q <= 1'b0;
      out_q  <= '0;
    end else begin
      xfer_q <= xfer_n;
      dreq_q <= dreq_n;
      out_q  <= out_n;
    end
  end

  assign dout = out_q;
  assign dreq = dreq_q;

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_q |=> $stable(out_q)); // R5
  AST_DMA_WITH_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_q |-> xfer_q); // R11
endmodule

// File: rtl/dac_hold_trig.sv
module dac_hold_trig
  import dac_pkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int BW          = BUS_W,
  parameter int AW          = ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          tmr_a,
  input  logic          tmr_b,
  input  logic          ext_trig,
  output logic [DW-1:0] dout0,
  output logic [DW-1:0] dout1,
  output logic [1:0]    dma_req,
  output logic [1:0]    ch_en,
  output logic [1:0]    buf_off
);
  chan_cfg_t [NCH-1:0]    cfg;
  logic [NCH-1:0]         sw_pend, sw_take, commit;
  logic [NCH-1:0][DW-1:0] hold, dout;
  logic                   ext_rise;

  dac_cfg_regs #(.AW(AW), .BW(BW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_take(sw_take), .cfg(cfg), .sw_pend(sw_pend)
  );

  dac_hold #(.DW(DW), .BW(BW), .AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hold(hold), .commit(commit)
  );

  dac_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_trig), .rise(ext_rise)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_chan_xfer #(.DW(DW)) u_xfer (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[c]), .tmr_a(tmr_a), .tmr_b(tmr_b),
      .ext_rise(ext_rise), .sw_pend(sw_pend[c]), .commit(commit[c]), .hold(hold[c]),
      .dout(dout[c]), .dreq(dma_req[c]), .take_sw(sw_take[c])
    );
    assign ch_en[c]   = cfg[c].en;
    assign buf_off[c] = cfg[c].buf_off;

    AST_SW_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] |-> $past(cfg[c].src) != SRC_SW); // R11
    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg[c].en && !$past(cfg[c].en)) |=> $stable(dout[c])); // R6
  end

  assign dout0 = dout[0];
  assign dout1 = dout[1];
endmodule

// File: tb/dac_hold_trig_test.sv
module dac_hold_trig_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tmr_a = 1'b0, tmr_b = 1'b0, ext_trig = 1'b0;
  logic [11:0] dout0, dout1;
  logic [1:0]  dma_req, ch_en, buf_off;

  int    checks = 0, failures = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_hold_trig uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .ext_trig(ext_trig),
    .dout0(dout0), .dout1(dout1), .dma_req(dma_req), .ch_en(ch_en), .buf_off(buf_off)
  );

  // Behavioural reference model, stepped on every rising edge.
  logic [5:0]  m_cfg [2];
  logic [11:0] m_hold [2], m_out [2];
  logic [3:0]  m_rhi [2];
  logic [7:0]  m_lhi [2];
  logic [7:0]  m_d8, m_dlo;
  logic [1:0]  m_sw, m_x, m_d;
  logic [2:0]  m_e;
  logic [5:0]  n_cfg [2];
  logic [11:0] n_hold [2], n_out [2];
  logic [3:0]  n_rhi [2];
  logic [7:0]  n_lhi [2];
  logic [7:0]  n_d8, n_dlo;
  logic [1:0]  n_sw, n_x, n_d, hit, com;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cfg[c] = '0; m_hold[c] = '0; m_out[c] = '0; m_rhi[c] = '0; m_lhi[c] = '0;
      end
      m_d8 = '0; m_dlo = '0; m_sw = '0; m_x = '0; m_d = '0; m_e = '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        n_cfg[c] = m_cfg[c]; n_hold[c] = m_hold[c]; n_rhi[c] = m_rhi[c]; n_lhi[c] = m_lhi[c];
        n_out[c] = m_x[c] ? m_hold[c] : m_out[c];
        case (m_cfg[c][3:2])
          2'd0: hit[c] = tmr_a;
          2'd1: hit[c] = tmr_b;
          2'd2: hit[c] = m_e[1] & ~m_e[2];
          default: hit[c] = m_sw[c];
        endcase
        hit[c] = hit[c] & m_cfg[c][0] & m_cfg[c][1];
        com[c] = 1'b0;
      end
      n_d8 = m_d8; n_dlo = m_dlo;
      if (wr_en) begin
        for (int c = 0; c < 2; c++) begin
          int b;
          b = 4 + 5*c;
          if (int'(wr_addr) == c) begin
            n_cfg[c] = wr_data[5:0];
            if (m_cfg[c][0]) n_cfg[c][3:2] = m_cfg[c][3:2];
          end
          if (int'(wr_addr) == b)     n_rhi[c] = wr_data[3:0];
          if (int'(wr_addr) == b + 1) begin n_hold[c] = {m_rhi[c], wr_data}; com[c] = 1'b1; end
          if (int'(wr_addr) == b + 2) n_lhi[c] = wr_data;
          if (int'(wr_addr) == b + 3) begin n_hold[c] = {m_lhi[c], wr_data[7:4]}; com[c] = 1'b1; end
          if (int'(wr_addr) == b + 4) begin n_hold[c] = {wr_data, 4'h0}; com[c] = 1'b1; end
        end
        case (int'(wr_addr))
          14: n_d8 = wr_data;
          15: begin n_hold[0] = {m_d8, 4'h0}; n_hold[1] = {wr_data, 4'h0}; com = 2'b11; end
          16: n_rhi[0] = wr_data[3:0];
          17: n_dlo = wr_data;
          18: n_rhi[1] = wr_data[3:0];
          19: begin n_hold[0] = {m_rhi[0], m_dlo}; n_hold[1] = {m_rhi[1], wr_data}; com = 2'b11; end
          default: ;
        endcase
      end
      for (int c = 0; c < 2; c++) begin
        n_x[c]  = m_cfg[c][0] & (m_cfg[c][1] ? hit[c] : com[c]);
        n_d[c]  = hit[c] & m_cfg[c][5] & (m_cfg[c][3:2] != 2'd3);
        n_sw[c] = m_sw[c] & ~(hit[c] & (m_cfg[c][3:2] == 2'd3));
      end
      if (wr_en && wr_addr == 5'd2) n_sw = n_sw | wr_data[1:0];
      m_e = {m_e[1:0], ext_trig};
      for (int c = 0; c < 2; c++) begin
        m_cfg[c] = n_cfg[c]; m_hold[c] = n_hold[c]; m_out[c] = n_out[c];
        m_rhi[c] = n_rhi[c]; m_lhi[c] = n_lhi[c];
      end
      m_d8 = n_d8; m_dlo = n_dlo; m_sw = n_sw; m_x = n_x; m_d = n_d;
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, tagged with the phase's requirement.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "model dout0", int'(dout0), int'(m_out[0]));
      chk(cur_req, "model dout1", int'(dout1), int'(m_out[1]));
      chk(cur_req, "model dma_req", int'(dma_req), int'(m_d));
      chk("R13", "model ch_en", int'(ch_en), int'({m_cfg[1][0], m_cfg[0][0]}));
      chk("R13", "model buf_off", int'(buf_off), int'({m_cfg[1][4], m_cfg[0][4]}));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit which_b);
    @(negedge clk); if (which_b) tmr_b = 1'b1; else tmr_a = 1'b1;
    @(negedge clk); tmr_a = 1'b0; tmr_b = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    cur_req = "R1";
    chk("R1", "reset dout0", int'(dout0), 0);
    chk("R1", "reset dout1", int'(dout1), 0);
    chk("R1", "reset dma_req", int'(dma_req), 0);
    chk("R1", "reset ch_en", int'(ch_en), 0);

    cur_req = "R13";
    wr(5'd0, 8'h11);
    chk("R13", "buf_off set", int'(buf_off), 1);
    chk("R13", "ch_en set", int'(ch_en), 1);
    wr(5'd0, 8'h01);
    wr(5'd1, 8'h01);
    chk("R13", "both enabled", int'(ch_en), 3);

    cur_req = "R2";
    wr(5'd4, 8'h0A);
    idle(3);
    chk("R2", "high nibble alone", int'(dout0), 0);
    wr(5'd5, 8'h5C);
    chk("R5", "not yet after write edge", int'(dout0), 0);
    idle(1);
    chk("R5", "right12 value at second edge", int'(dout0), 'hA5C);

    cur_req = "R3";
    wr(5'd6, 8'h3C); wr(5'd7, 8'h9F); idle(2);
    chk("R3", "left12 value", int'(dout0), 'h3C9);

    cur_req = "R4";
    wr(5'd8, 8'hE7); idle(2);
    chk("R4", "8-bit value", int'(dout0), 'hE70);
    wr(5'd9, 8'h0B); wr(5'd10, 8'hCD); idle(2);
    chk("R2", "ch1 right12", int'(dout1), 'hBCD);
    wr(5'd13, 8'h42); idle(2);
    chk("R4", "ch1 8-bit", int'(dout1), 'h420);

    cur_req = "R12";
    wr(5'd14, 8'h11); wr(5'd15, 8'h22); idle(2);
    chk("R12", "dual8 ch0", int'(dout0), 'h110);
    chk("R12", "dual8 ch1", int'(dout1), 'h220);
    wr(5'd16, 8'h07); wr(5'd18, 8'h08); wr(5'd17, 8'h12); idle(2);
    chk("R12", "dual12 buffered", int'(dout0), 'h110);
    wr(5'd19, 8'h34); idle(2);
    chk("R12", "dual12 ch0", int'(dout0), 'h712);
    chk("R12", "dual12 ch1", int'(dout1), 'h834);

    cur_req = "R6";
    wr(5'd1, 8'h00); wr(5'd13, 8'h99); idle(3);
    chk("R6", "disabled ch1 frozen", int'(dout1), 'h834);

    cur_req = "R7";
    wr(5'd0, 8'h03); wr(5'd8, 8'h55); idle(3);
    chk("R7", "write without trigger", int'(dout0), 'h712);
    pulse(1'b0);
    chk("R7", "before update", int'(dout0), 'h712);
    chk("R11", "no dma when disabled", int'(dma_req), 0);
    idle(1);
    chk("R7", "timer A transfer", int'(dout0), 'h550);
    wr(5'd8, 8'h66); pulse(1'b1); idle(3);
    chk("R7", "other timer ignored", int'(dout0), 'h550);

    cur_req = "R10";
    wr(5'd0, 8'h07); pulse(1'b1); idle(3);
    chk("R10", "source locked, B ignored", int'(dout0), 'h550);
    pulse(1'b0); idle(2);
    chk("R10", "source still A", int'(dout0), 'h660);
    wr(5'd0, 8'h06);
    chk("R10", "enable cleared", int'(ch_en), 0);
    wr(5'd0, 8'h27);

    cur_req = "R11";
    wr(5'd8, 8'h77); pulse(1'b1);
    chk("R11", "dma pulse", int'(dma_req), 1);
    chk("R11", "output not yet", int'(dout0), 'h660);
    idle(1);
    chk("R11", "dma one cycle", int'(dma_req), 0);
    chk("R11", "output updated", int'(dout0), 'h770);

    cur_req = "R8";
    wr(5'd0, 8'h00); wr(5'd0, 8'h2B); wr(5'd8, 8'h88);
    @(negedge clk); ext_trig = 1'b1;
    idle(3);
    chk("R8", "sync latency not done", int'(dout0), 'h770);
    idle(1);
    chk("R8", "ext transfer", int'(dout0), 'h880);
    wr(5'd8, 8'h99); idle(5);
    chk("R8", "held high no retrigger", int'(dout0), 'h880);
    @(negedge clk); ext_trig = 1'b0;
    idle(5);
    chk("R8", "falling edge ignored", int'(dout0), 'h880);

    cur_req = "R9";
    wr(5'd0, 8'h00); wr(5'd0, 8'h2F); wr(5'd8, 8'hAB);
    wr(5'd2, 8'h01);
    chk("R9", "sw after write edge", int'(dout0), 'h880);
    idle(1);
    chk("R9", "sw second edge", int'(dout0), 'h880);
    chk("R11", "sw never dma", int'(dma_req), 0);
    idle(1);
    chk("R9", "sw transfer", int'(dout0), 'hAB0);
    wr(5'd8, 8'hCD); idle(4);
    chk("R9", "sw bit cleared", int'(dout0), 'hAB0);
    chk("R11", "sw never dma later", int'(dma_req), 0);

    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule